// File: doc/BRIEF.md
# Downstream Port Power and Over-Current Manager

This block drives the power switches of the downstream ports of a hub and watches an over-current flag from each switch. Hub logic asks for power on or off with single-cycle command pulses; the block drives an active-low enable for each switch. An over-current flag must stay asserted for a filter window of several milliseconds while that port is powered before the block treats it as a real fault. A confirmed fault cuts the power and latches a status bit, and the port stays off until hub logic clears the bit and sends a new power-on command.

Two static mode inputs select how ports are grouped. With ganged power, any port's on or off command applies to every port. With global over-current, a fault on any port is reported on every port. Whenever either grouping is selected, a confirmed fault removes power from all ports. The millisecond time base comes from a prescaler on the core clock. Every interface is plain control and status: commands are single-cycle pulses and there is no valid/ready handshake, because nothing here is a data stream and nothing can be held back.

Top module: `port_power_mgr`

## Requirements
- R1: Polarity and reset. `pwr_en_n[i]` low means port i is powered, and `oc_sense_n[i]` low means port i reports over-current. After reset every `pwr_en_n` bit is 1 and every `oc_flag` bit is 0.
- R2: Individual power. With `gang_pwr`=0, a pulse on `pwr_on[i]` powers port i from the next clock on, and a pulse on `pwr_off[i]` unpowers it. Other ports are unaffected. If both arrive in the same cycle, off wins.
- R3: Ganged power. With `gang_pwr`=1, an on or off pulse on any bit of `pwr_on` or `pwr_off` applies to all ports together.
- R4: While port i is unpowered, a low level on `oc_sense_n[i]` has no effect. The filter stays at zero, no flag is set, and no power changes.
- R5: Filter delay. When a powered port's sense input goes low and stays low, its power is cut no sooner than FILT_MS*TICK_DIV clock cycles and no later than (FILT_MS+1)*TICK_DIV+4 clock cycles afterwards. One millisecond tick lasts TICK_DIV cycles.
- R6: Glitch rejection. If a low pulse on a sense input lasts at most (FILT_MS-1)*TICK_DIV cycles, it causes no fault. The filter restarts from zero each time the input returns high, so repeated short pulses never add up to a fault.
- R7: Individual reporting. With `gang_pwr`=0 and `glob_oc`=0, a confirmed fault on port i cuts only port i and sets only `oc_flag[i]`.
- R8: Spreading. With `glob_oc`=1 or `gang_pwr`=1, a confirmed fault on any port cuts power on every port and sets every `oc_flag` bit.
- R9: Latching. While `oc_flag[i]` is set, power-on commands for port i are ignored. In ganged mode, power-on commands are ignored while any flag is set. A pulse on `oc_clr[i]` clears `oc_flag[i]` and leaves the port off until a new power-on command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gang_pwr | input | 1 | Static: 1 = ganged power control |
| glob_oc | input | 1 | Static: 1 = global over-current reporting |
| pwr_on | input | NUM_PORTS | Per-port power-on command pulse |
| pwr_off | input | NUM_PORTS | Per-port power-off command pulse |
| oc_clr | input | NUM_PORTS | Per-port fault clear pulse |
| oc_sense_n | input | NUM_PORTS | Active-low over-current sense from the switches |
| pwr_en_n | output | NUM_PORTS | Active-low switch enables |
| oc_flag | output | NUM_PORTS | Latched over-current status |

## Verification
The bench measures the exact cycle count from a sense input going low to the switch opening, on each port. A filter that is off by one tick fails the lower or upper bound of the window. It sends trains of low pulses that are each too short to confirm but add up to more than the window; a counter that does not restart on release would latch a false fault here. It holds the sense input low on an unpowered port, which a filter not qualified by power would turn into a fault. It also repeats faults in individual, global and ganged modes and then tries power-on before and after clearing. A design that does not spread the fault, or that lets power return while the fault is latched or straight after a clear, shows the wrong enable or flag pattern.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  function automatic int ppm_cw(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ppm_tick.sv
module ppm_tick
  import ppm_pkg::*;
#(
  parameter int TICK_DIV = 30000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = ppm_cw(TICK_DIV);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (pre_q == PW'(TICK_DIV - 1)) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  assign tick = (pre_q == PW'(TICK_DIV - 1));

  generate
    if (TICK_DIV > 1) begin : g_gap
      p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("tick repeated on consecutive cycles");
    end
  endgenerate
endmodule

// File: rtl/ppm_oc_filter.sv
module ppm_oc_filter
  import ppm_pkg::*;
#(
  parameter int FILT_MS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_n,
  input  logic pwr_on,
  input  logic tick,
  output logic confirm
);
  localparam int CW = ppm_cw(FILT_MS + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= ~sense_n;
      s2_q <= s1_q;
    end
  end

  assign active  = s2_q & pwr_on;
  assign confirm = active & tick & (cnt_q == CW'(FILT_MS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else if (tick && cnt_q != CW'(FILT_MS)) cnt_q <= cnt_q + 1'b1;
  end

  p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (cnt_q == '0))
    else $error("filter counted while port unpowered");

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FILT_MS))
    else $error("filter count beyond window");
endmodule

// File: rtl/ppm_port_ctrl.sv
module ppm_port_ctrl #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gang_pwr,
  input  logic                 glob_oc,
  input  logic [NUM_PORTS-1:0] on_cmd,
  input  logic [NUM_PORTS-1:0] off_cmd,
  input  logic [NUM_PORTS-1:0] clr_cmd,
  input  logic [NUM_PORTS-1:0] confirm,
  output logic [NUM_PORTS-1:0] pwr_q,
  output logic [NUM_PORTS-1:0] fault_q
);
  localparam logic [NUM_PORTS-1:0] ALL = {NUM_PORTS{1'b1}};

  logic                 spread;
  logic [NUM_PORTS-1:0] fault_set, on_eff, off_eff, blocked;
  logic [NUM_PORTS-1:0] pwr_d, fault_d;

  assign spread    = gang_pwr | glob_oc;
  assign fault_set = spread ? ((|confirm) ? ALL : '0) : confirm;
  assign on_eff    = gang_pwr ? ((|on_cmd) ? ALL : '0) : on_cmd;
  assign off_eff   = gang_pwr ? ((|off_cmd) ? ALL : '0) : off_cmd;
  assign blocked   = gang_pwr ? ((|fault_q) ? ALL : '0) : fault_q;

  always_comb begin
    fault_d = (fault_q & ~clr_cmd) | fault_set;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (fault_set[i] || off_eff[i]) pwr_d[i] = 1'b0;
      else if (on_eff[i] && !blocked[i]) pwr_d[i] = 1'b1;
      else pwr_d[i] = pwr_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= '0;
      fault_q <= '0;
    end else begin
      pwr_q   <= pwr_d;
      fault_q <= fault_d;
    end
  end

  p_cut_on_confirm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|confirm) |=> ((pwr_q & $past(confirm)) == '0))
    else $error("power still on after confirmed fault");

  p_spread_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|confirm) && spread) |=> (pwr_q == '0 && fault_q == ALL))
    else $error("fault not spread to all ports");

  p_off_while_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q & fault_q) == '0)
    else $error("port powered while fault latched");
endmodule

// File: rtl/port_power_mgr.sv
module port_power_mgr #(
  parameter int NUM_PORTS = 4,
  parameter int TICK_DIV  = 30000,
  parameter int FILT_MS   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gang_pwr,
  input  logic                 glob_oc,
  input  logic [NUM_PORTS-1:0] pwr_on,
  input  logic [NUM_PORTS-1:0] pwr_off,
  input  logic [NUM_PORTS-1:0] oc_clr,
  input  logic [NUM_PORTS-1:0] oc_sense_n,
  output logic [NUM_PORTS-1:0] pwr_en_n,
  output logic [NUM_PORTS-1:0] oc_flag
);
  logic                 tick;
  logic [NUM_PORTS-1:0] confirm, pwr_q, fault_q;

  ppm_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      ppm_oc_filter #(.FILT_MS(FILT_MS)) u_filt (
        .clk(clk), .rst_n(rst_n), .sense_n(oc_sense_n[i]),
        .pwr_on(pwr_q[i]), .tick(tick), .confirm(confirm[i])
      );
    end
  endgenerate

  ppm_port_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .gang_pwr(gang_pwr), .glob_oc(glob_oc),
    .on_cmd(pwr_on), .off_cmd(pwr_off), .clr_cmd(oc_clr),
    .confirm(confirm), .pwr_q(pwr_q), .fault_q(fault_q)
  );

  assign pwr_en_n = ~pwr_q;
  assign oc_flag  = fault_q;

  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pwr_en_n == '1 && oc_flag == '0))
    else $error("outputs not in reset state");
endmodule

// File: tb/test_port_power_mgr.sv
module test_port_power_mgr;
  localparam int N    = 4;
  localparam int DIV  = 8;
  localparam int FILT = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gang_pwr = 1'b0, glob_oc = 1'b0;
  logic [N-1:0] pwr_on = '0, pwr_off = '0, oc_clr = '0;
  logic [N-1:0] oc_sense_n = '1;
  logic [N-1:0] pwr_en_n, oc_flag;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  port_power_mgr #(.NUM_PORTS(N), .TICK_DIV(DIV), .FILT_MS(FILT)) i_port_power_mgr (
    .clk(clk), .rst_n(rst_n), .gang_pwr(gang_pwr), .glob_oc(glob_oc),
    .pwr_on(pwr_on), .pwr_off(pwr_off), .oc_clr(oc_clr),
    .oc_sense_n(oc_sense_n), .pwr_en_n(pwr_en_n), .oc_flag(oc_flag)
  );

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd_on(input logic [N-1:0] m);
    @(negedge clk) pwr_on = m;
    @(negedge clk) pwr_on = '0;
  endtask

  task automatic cmd_off(input logic [N-1:0] m);
    @(negedge clk) pwr_off = m;
    @(negedge clk) pwr_off = '0;
  endtask

  task automatic cmd_clr(input logic [N-1:0] m);
    @(negedge clk) oc_clr = m;
    @(negedge clk) oc_clr = '0;
  endtask

  // hold sense low on port p until power drops; return elapsed cycles
  task automatic fault_on(input int p, output int n);
    @(negedge clk) oc_sense_n[p] = 1'b0;
    n = 0;
    while (pwr_en_n[p] == 1'b0 && n < 20 * DIV) begin
      @(negedge clk);
      n++;
    end
    oc_sense_n[p] = 1'b1;
    cyc(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk(pwr_en_n, 4'hF, "R1 reset enables");
    chk(oc_flag, 0, "R1 reset flags");

    // R2 exhaustive individual on patterns
    for (int m = 0; m < 16; m++) begin
      cmd_off('1);
      cmd_on(4'(m));
      chk(pwr_en_n, (~m) & 4'hF, "R2 individual on pattern");
    end
    cmd_on('1);
    for (int p = 0; p < N; p++) begin
      cmd_off(4'(1 << p));
      chk(pwr_en_n, 1 << p, "R2 individual off");
      cmd_on(4'(1 << p));
    end
    @(negedge clk) begin pwr_on = 4'h2; pwr_off = 4'h2; end
    @(negedge clk) begin pwr_on = '0; pwr_off = '0; end
    chk(pwr_en_n, 4'h2, "R2 off wins over on");

    // R3 ganged
    cmd_off('1);
    gang_pwr = 1'b1;
    for (int p = 0; p < N; p++) begin
      cmd_on(4'(1 << p));
      chk(pwr_en_n, 0, "R3 ganged on from one bit");
      cmd_off(4'(1 << p));
      chk(pwr_en_n, 4'hF, "R3 ganged off from one bit");
    end
    gang_pwr = 1'b0;

    // R4 sense ignored while unpowered
    cmd_on(4'hD);
    @(negedge clk) oc_sense_n[1] = 1'b0;
    cyc(8 * DIV);
    chk(oc_flag, 0, "R4 no flag on unpowered port");
    chk(pwr_en_n, 4'h2, "R4 powers unchanged");
    @(negedge clk) oc_sense_n[1] = 1'b1;
    cyc(4);
    cmd_on(4'h2);
    chk(pwr_en_n, 0, "R4 port powers after release");

    // R6 glitch trains
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk) oc_sense_n[p] = 1'b0;
        cyc((FILT - 1) * DIV - 1);
        @(negedge clk) oc_sense_n[p] = 1'b1;
        cyc(2 * DIV);
      end
      chk(oc_flag, 0, "R6 glitch train no fault");
      chk(pwr_en_n, 0, "R6 power kept");
    end

    // R5 R7 R9 individual fault per port
    for (int p = 0; p < N; p++) begin
      cmd_on('1);
      fault_on(p, n);
      total++;
      if (n < FILT * DIV || n > (FILT + 1) * DIV + 4) begin
        bad++;
        $display("FAIL R5 delay actual=%0d expected=%0d..%0d", n, FILT * DIV,
                 (FILT + 1) * DIV + 4);
      end
      chk(pwr_en_n, 1 << p, "R7 only faulted port off");
      chk(oc_flag, 1 << p, "R7 only faulted flag");
      cmd_on(4'(1 << p));
      chk(pwr_en_n, 1 << p, "R9 on ignored while latched");
      cmd_clr(4'(1 << p));
      chk(oc_flag, 0, "R9 clear drops flag");
      chk(pwr_en_n, 1 << p, "R9 stays off after clear");
      cmd_on(4'(1 << p));
      chk(pwr_en_n, 0, "R9 new on restores power");
    end

    // R8 global reporting
    glob_oc = 1'b1;
    for (int p = 0; p < N; p++) begin
      cmd_on('1);
      fault_on(p, n);
      chk(pwr_en_n, 4'hF, "R8 global cuts all");
      chk(oc_flag, 4'hF, "R8 global flags all");
      cmd_clr('1);
      chk(oc_flag, 0, "R8 global clear");
    end
    glob_oc = 1'b0;

    // R8 R9 ganged fault
    gang_pwr = 1'b1;
    cmd_on(4'h1);
    fault_on(3, n);
    chk(pwr_en_n, 4'hF, "R8 ganged cuts all");
    chk(oc_flag, 4'hF, "R8 ganged flags all");
    cmd_clr(4'h7);
    cmd_on(4'h1);
    chk(pwr_en_n, 4'hF, "R9 ganged blocked by any flag");
    cmd_clr(4'h8);
    cmd_on(4'h4);
    chk(pwr_en_n, 0, "R9 ganged restore");
    gang_pwr = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule